// File: doc/BRIEF.md
# Calendar Timekeeper with Write-Busy Flags

The block keeps a running time of day and a calendar date. Both advance once per second. A prescaler on a slow 32.768 kHz clock produces that one-second tick. Software reaches the block through a small word-addressed register port on a fast bus clock. Word 1 holds the time, word 2 holds the date, and word 0 is a control word that carries two busy flags.

The counters live in the slow clock domain. A write to the time word or the date word does not take effect at once. The block captures the value in the bus domain and passes it across with a four-phase request/acknowledge handshake. The matching busy flag stays high until the acknowledge has returned and then fallen again. The year is kept as an offset from 2010, so the 6-bit default field covers 2010 to 2073. The leap-year flag is never computed: software writes it together with the date, and it decides the length of February.

Reads are taken straight from the slow-domain counters. A read can therefore land in the middle of a carry. Software reads a word twice and accepts the value when both reads agree.

Top module: `rtc_calendar`

## Requirements
- R1: The time word (address 1) holds seconds in bits [5:0], minutes in bits [13:8] and hours in bits [20:16]; all other bits read 0.
- R2: The date word (address 2) holds day of month in bits [4:0], month 1..12 in bits [11:8], the year offset from 2010 in bits [21:16] and the leap flag in bit 22; all other bits read 0; the leap flag reads back exactly as written.
- R3: An accepted write to the time word sets control-word bit 8, and an accepted write to the date word sets control-word bit 7. Each bit reads 1 from the bus cycle after the write until the new value is in force, then returns to 0. A write to one word leaves the other word's bit at 0.
- R4: A write to the time or date word while that word's busy bit is 1 is dropped; the value already in flight is the one that takes effect.
- R5: Each tick advances the seconds. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0 and carry into the date.
- R6: On a day carry, the day increments, or returns to 1 with a month increment when it is the month's last day. Months 4, 6, 9 and 11 have 30 days. February has 29 days with the leap flag set and 28 without. All other months have 31 days.
- R7: A day carry out of month 12 sets the month to 1 and increments the year offset, which wraps from 63 to 0. Counting never changes the leap flag.
- R8: A write to the time word restarts the prescaler, so the loaded time holds for one full second before its first increment.
- R9: A write to the time word leaves the date unchanged, and a write to the date word leaves the time unchanged.
- R10: After reset the control word reads 0, the time reads 00:00:00 and the date reads day 1, month 1, offset 0, leap flag 0.
- R11: Address 3 reads 0, and writes to addresses 0 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| slow_clk_i | input | 1 | 32.768 kHz counting clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| addr_i | input | 2 | Word address: 0 control, 1 time, 2 date |
| wr_en_i | input | 1 | Write strobe, one bus cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |

## Verification
The seconds field is swept through all 60 values. Each sweep point uses a different minute and hour, so a single-step increment is told apart from a wrong carry. The hours field is swept through all 24 values at 59:59, which separates the minute-to-hour carry from the 23-to-0 wrap and its day carry. Every month is started on its last day, with the leap flag both clear and set, and the bench confirms that the 28-, 29-, 30- and 31-day lengths and the December year carry each land on the right next date. The remaining tests are a write issued during busy, the 63-to-0 year wrap, and February 28 with the leap flag set; they isolate the dropping of writes, the wrap of the year offset and the use of the flag.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HOUR_LSB = 16;
  localparam int DAY_LSB  = 0;
  localparam int MON_LSB  = 8;
  localparam int YEAR_LSB = 16;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TIME = 2'd1;
  localparam logic [1:0] ADDR_DATE = 2'd2;

  localparam int BUSY_TIME_BIT = 8;
  localparam int BUSY_DATE_BIT = 7;

  typedef struct packed {
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } tod_t;

  function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                   days_in_month = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: days_in_month = 5'd30;
      default:                days_in_month = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_xfer.sv
// Four-phase request/acknowledge transfer of a held word into the slow domain.
module rtc_xfer #(
  parameter int W = 17
) (
  input  logic         bus_clk_i,
  input  logic         slow_clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic [W-1:0] data_o,
  output logic         load_o
);
  logic         req_q;
  logic [W-1:0] hold_q;
  logic         ack_b1_q, ack_b2_q;
  logic         req_s1_q, req_s2_q, ack_q;
  logic         accept;

  assign busy_o = req_q | ack_b2_q;
  assign accept = wr_i & ~busy_o;

  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (accept) begin
      req_q  <= 1'b1;
      hold_q <= wdata_i;
    end else if (ack_b2_q) begin
      req_q  <= 1'b0;
    end
  end

  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_b1_q <= 1'b0;
      ack_b2_q <= 1'b0;
    end else begin
      ack_b1_q <= ack_q;
      ack_b2_q <= ack_b1_q;
    end
  end

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_s1_q <= 1'b0;
      req_s2_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      req_s1_q <= req_q;
      req_s2_q <= req_s1_q;
      ack_q    <= req_s2_q;
    end
  end

  assign load_o = req_s2_q & ~ack_q;
  assign data_o = hold_q;

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o) |=> busy_o); // R3
  AST_HELD_WHILE_BUSY: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(hold_q)); // R4
  AST_LOAD_SINGLE: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    load_o |=> !load_o); // R3
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  AST_CLEAR_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_cal_pkg::*;
#(
  parameter int YEAR_W = 6,
  localparam int DATE_W = 5 + 4 + YEAR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tload_i,
  input  tod_t              tdata_i,
  input  logic              dload_i,
  input  logic [DATE_W-1:0] ddata_i,
  output logic [31:0]       time_o,
  output logic [31:0]       date_o
);
  localparam int LEAP_BIT = YEAR_LSB + YEAR_W;

  logic [5:0]        sec_q, min_q;
  logic [4:0]        hour_q, day_q;
  logic [3:0]        mon_q;
  logic [YEAR_W-1:0] year_q;
  logic              leap_q;

  logic       sec_wrap, min_wrap, hour_wrap, day_inc, last_day, last_mon;
  logic [4:0] mdays;

  assign sec_wrap  = (sec_q == 6'd59);
  assign min_wrap  = (min_q == 6'd59);
  assign hour_wrap = (hour_q == 5'd23);
  assign day_inc   = tick_i & sec_wrap & min_wrap & hour_wrap;
  assign mdays     = days_in_month(mon_q, leap_q);
  assign last_day  = (day_q >= mdays);
  assign last_mon  = (mon_q >= 4'd12);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else if (tload_i) begin
      sec_q  <= tdata_i.sec;
      min_q  <= tdata_i.min;
      hour_q <= tdata_i.hour;
    end else if (tick_i) begin
      sec_q <= sec_wrap ? 6'd0 : sec_q + 6'd1;
      if (sec_wrap) begin
        min_q <= min_wrap ? 6'd0 : min_q + 6'd1;
        if (min_wrap) hour_q <= hour_wrap ? 5'd0 : hour_q + 5'd1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      day_q  <= 5'd1;
      mon_q  <= 4'd1;
      year_q <= '0;
      leap_q <= 1'b0;
    end else if (dload_i) begin
      {leap_q, year_q, mon_q, day_q} <= ddata_i;
    end else if (day_inc) begin
      if (last_day) begin
        day_q <= 5'd1;
        if (last_mon) begin
          mon_q  <= 4'd1;
          year_q <= year_q + 1'b1;
        end else begin
          mon_q <= mon_q + 4'd1;
        end
      end else begin
        day_q <= day_q + 5'd1;
      end
    end
  end

  always_comb begin
    time_o = '0;
    time_o[SEC_LSB +: 6]  = sec_q;
    time_o[MIN_LSB +: 6]  = min_q;
    time_o[HOUR_LSB +: 5] = hour_q;
    date_o = '0;
    date_o[DAY_LSB +: 5]       = day_q;
    date_o[MON_LSB +: 4]       = mon_q;
    date_o[YEAR_LSB +: YEAR_W] = year_q;
    date_o[LEAP_BIT]           = leap_q;
  end

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !tload_i && sec_q == 6'd59) |=> (sec_q == 6'd0)); // R5
  AST_TIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !tload_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q))); // R8
  AST_DATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!day_inc && !dload_i) |=> ($stable(day_q) && $stable(mon_q) && $stable(year_q))); // R9
  AST_LEAP_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dload_i |=> $stable(leap_q)); // R7
  AST_DAY_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_inc && !dload_i && day_q == 5'd31) |=> (day_q == 5'd1)); // R6
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int PRESC_DIV = 32768,
  parameter int YEAR_W    = 6
) (
  input  logic        clk_i,
  input  logic        slow_clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int TIME_W   = $bits(tod_t);
  localparam int DATE_W   = 5 + 4 + YEAR_W + 1;
  localparam int LEAP_BIT = YEAR_LSB + YEAR_W;

  tod_t              twr, tnew;
  logic [DATE_W-1:0] dwr, dnew;
  logic [TIME_W-1:0] tnew_raw;
  logic              wr_time, wr_date;
  logic              busy_time, busy_date, tload, dload, tick;
  logic [31:0]       time_w, date_w;
  logic              unused_wbits;

  assign wr_time = wr_en_i & (addr_i == ADDR_TIME);
  assign wr_date = wr_en_i & (addr_i == ADDR_DATE);

  assign twr.sec  = wdata_i[SEC_LSB +: 6];
  assign twr.min  = wdata_i[MIN_LSB +: 6];
  assign twr.hour = wdata_i[HOUR_LSB +: 5];
  assign dwr = {wdata_i[LEAP_BIT], wdata_i[YEAR_LSB +: YEAR_W],
                wdata_i[MON_LSB +: 4], wdata_i[DAY_LSB +: 5]};
  assign unused_wbits = ^{wdata_i[31:LEAP_BIT+1], wdata_i[15:14], wdata_i[7:6]};

  rtc_xfer #(.W(TIME_W)) u_time_xfer (
    .bus_clk_i (clk_i),
    .slow_clk_i(slow_clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_time),
    .wdata_i   (twr),
    .busy_o    (busy_time),
    .data_o    (tnew_raw),
    .load_o    (tload)
  );
  assign tnew = tod_t'(tnew_raw);

  rtc_xfer #(.W(DATE_W)) u_date_xfer (
    .bus_clk_i (clk_i),
    .slow_clk_i(slow_clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_date),
    .wdata_i   (dwr),
    .busy_o    (busy_date),
    .data_o    (dnew),
    .load_o    (dload)
  );

  rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk_i (slow_clk_i),
    .rst_ni(rst_ni),
    .clr_i (tload),
    .tick_o(tick)
  );

  rtc_cal_core #(.YEAR_W(YEAR_W)) u_core (
    .clk_i  (slow_clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .tload_i(tload),
    .tdata_i(tnew),
    .dload_i(dload),
    .ddata_i(dnew),
    .time_o (time_w),
    .date_o (date_w)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[BUSY_TIME_BIT] = busy_time;
        rdata_o[BUSY_DATE_BIT] = busy_date;
      end
      ADDR_TIME: rdata_o = time_w;
      ADDR_DATE: rdata_o = date_w;
      default:   rdata_o = '0;
    endcase
  end

  AST_TIME_WR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_time && !busy_time) |=> (busy_time && !busy_date || busy_date)); // R3
  AST_TIME_WR_NO_DATE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_time && !busy_date) |=> !busy_date); // R3
endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DIV = 16;

  logic        clk = 1'b0, sclk = 1'b0, rst_n = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;
  always #18.5 sclk = ~sclk;

  rtc_calendar #(.PRESC_DIV(DIV), .YEAR_W(6)) uut (
    .clk_i(clk), .slow_clk_i(sclk), .rst_ni(rst_n), .addr_i(addr),
    .wr_en_i(wr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [31:0] pt(int h, int m, int s);
    return 32'((h << 16) | (m << 8) | s);
  endfunction

  function automatic logic [31:0] pd(int d, int mo, int y, int lp);
    return 32'((lp << 22) | (y << 16) | (mo << 8) | d);
  endfunction

  function automatic int mdays(int mo, int lp);
    if (mo == 2) return 28 + lp;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] next_t(int h, int m, int s);
    int t;
    t = (h * 3600 + m * 60 + s + 1) % 86400;
    return pt(t / 3600, (t / 60) % 60, t % 60);
  endfunction

  function automatic logic [31:0] next_d(int d, int mo, int y, int lp);
    if (d < mdays(mo, lp)) return pd(d + 1, mo, y, lp);
    if (mo < 12) return pd(1, mo + 1, y, lp);
    return pd(1, 1, (y + 1) % 64, lp);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    logic [31:0] x, y;
    @(negedge clk);
    addr = a;
    #1 x = rdata;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      #1 y = rdata;
      if (y === x) break;
      x = y;
    end
    d = y;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a;
    wdata = d;
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 200; i++) begin
      rd(2'd0, c);
      if (c[8] == 1'b0 && c[7] == 1'b0) return;
    end
    check("R3 busy never cleared", c, 32'h0);
  endtask

  // load time and date, then confirm one tick gives the computed next values
  task automatic roll(input string tag, input int h, input int m, input int s,
                      input logic [31:0] dval, input logic [31:0] dexp);
    logic [31:0] v;
    wr_reg(2'd2, dval);
    wait_idle();
    wr_reg(2'd1, pt(h, m, s));
    wait_idle();
    rd(2'd1, v);
    check({tag, " R8 loaded time held"}, v, pt(h, m, s));
    rd(2'd2, v);
    check({tag, " R9 date intact after time write"}, v, dval);
    repeat (60) @(negedge clk);
    rd(2'd1, v);
    check({tag, " R5 time after one tick"}, v, next_t(h, m, s));
    rd(2'd2, v);
    check({tag, " R6 R7 date after one tick"}, v, dexp);
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd0, v); check("R10 ctrl after reset", v, 32'h0);
    rd(2'd1, v); check("R10 time after reset", v, 32'h0);
    rd(2'd2, v); check("R10 date after reset", v, pd(1, 1, 0, 0));
    rd(2'd3, v); check("R11 address 3 reads zero", v, 32'h0);

    // R3 time busy bit, R4 write during busy dropped
    wr_reg(2'd1, pt(10, 20, 30));
    rd(2'd0, v);
    check("R3 time busy set", 32'(v[8]), 32'd1);
    check("R3 date busy untouched", 32'(v[7]), 32'd0);
    wr_reg(2'd1, pt(1, 2, 3));
    wait_idle();
    rd(2'd1, v); check("R4 R1 in-flight value kept", v, pt(10, 20, 30));
    rd(2'd2, v); check("R9 date unchanged by time write", v, pd(1, 1, 0, 0));

    // R11 writes to control and unused address ignored
    wr_reg(2'd0, 32'hFFFF_FFFF);
    wr_reg(2'd3, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R11 ctrl write ignored", v, 32'h0);
    rd(2'd2, v); check("R11 date untouched", v, pd(1, 1, 0, 0));

    // R3 date busy bit, R2 layout
    wr_reg(2'd2, pd(15, 6, 5, 0) | 32'hFF80_F0E0);
    rd(2'd0, v);
    check("R3 date busy set", 32'(v[7]), 32'd1);
    check("R3 time busy untouched", 32'(v[8]), 32'd0);
    wait_idle();
    rd(2'd2, v); check("R2 date fields read back", v, pd(15, 6, 5, 0));
    rd(2'd1, v); check("R9 hours/minutes unchanged by date write", v & 32'hFFFF_FF00, pt(10, 20, 0));

    // R5 seconds sweep
    for (int s = 0; s < 60; s++)
      roll("R5 sec sweep", s % 24, (s * 7) % 60, s, pd(15, 6, 5, 0), pd(15, 6, 5, 0));

    // R5 hours sweep with carry into day at 23
    for (int h = 0; h < 24; h++)
      roll("R5 hour sweep", h, 59, 59, pd(15, 6, 5, 0),
           (h == 23) ? pd(16, 6, 5, 0) : pd(15, 6, 5, 0));

    // R6 R7 every month end, leap clear and set
    for (int lp = 0; lp < 2; lp++)
      for (int mo = 1; mo <= 12; mo++)
        roll("R6 month end", 23, 59, 59, pd(mdays(mo, lp), mo, 7, lp),
             next_d(mdays(mo, lp), mo, 7, lp));

    roll("R6 leap feb 28", 23, 59, 59, pd(28, 2, 7, 1), pd(29, 2, 7, 1));
    roll("R7 year carry", 23, 59, 59, pd(31, 12, 20, 0), pd(1, 1, 21, 0));
    roll("R7 year wrap", 23, 59, 59, pd(31, 12, 63, 1), pd(1, 1, 0, 1));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule